// File: doc/BRIEF.md
# UART Modem Control, Modem Status and Internal Loopback

This block handles the modem side of one UART channel. It holds a small control register that drives the DTR and RTS lines and selects loopback. It synchronises the four external modem status inputs (CTS, DSR, RI, CD) and keeps a modem status register. That register shows the current level of each line and a sticky change flag for each line. A modem-status interrupt request is raised when any change flag is set and the interrupt enable is high. The block also switches the serial streams between the external pins and the transmitter and receiver cores.

With loopback selected, the block cuts the channel off from the outside. The transmit stream is fed straight back to the receiver. The external TX pin idles high and DTR and RTS go inactive. The four status lines take their values from the low four control bits, so that software can move every status line and see its change flags in bits 0 to 3. All pins use active-high logical levels: 1 means asserted.

Top module: `uart_modem_loopback`

## Requirements
- R1: In loopback (control bit 4 = 1), `core_rx` equals `core_tx` and `pin_rx` has no effect. Out of loopback, `core_rx` equals `pin_rx` and `pin_tx` equals `core_tx`.
- R2: In loopback, `pin_tx` is 1 and `pin_dtr` and `pin_rts` are 0. Out of loopback, `pin_dtr` equals control bit 0 and `pin_rts` equals control bit 1.
- R3: In loopback, status bit 4 (CTS level) equals control bit 0, bit 5 (DSR level) equals control bit 1, bit 6 (RI level) equals control bit 2 and bit 7 (CD level) equals control bit 3. The external CTS, DSR, RI and CD pins change neither the levels nor the flags.
- R4: Out of loopback, status bits 7..4 show the CD, RI, DSR and CTS pins through a two-flop synchronizer, so a pin change appears after the second rising clock edge. A change of CTS, DSR or CD sets flag bit 0, 1 or 3 respectively at the third rising edge.
- R5: Flag bit 2 is set only when the RI level goes from 1 to 0. A rising RI level sets no flag.
- R6: Once set, a flag stays set until the status register is read.
- R7: A cycle with `sts_rd` high clears flag bits 3..0 at its closing edge. A change detected in that same cycle still sets its flag.
- R8: `irq_modem` is 1 exactly when `msi_en` is 1 and at least one of status bits 3..0 is 1. This holds in loopback as well.
- R9: A write stores `ctl_wdata[4:0]`. `ctl_rdata` returns those five bits, with bits 7..5 always 0.
- R10: After reset, the control register and all flags are 0 and `irq_modem` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit0 DTR, bit1 RTS, bit2 aux (RI in loopback), bit3 interrupt-out enable (CD in loopback), bit4 loopback |
| ctl_rdata | output | 8 | Control register contents |
| sts_rd | input | 1 | Status read strobe; clears the flags |
| sts_rdata | output | 8 | Status: bits 7..4 CD, RI, DSR, CTS levels; bits 3..0 CD-change, RI-trailing, DSR-change, CTS-change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| irq_modem | output | 1 | Modem-status interrupt request |
| pin_cts | input | 1 | External CTS |
| pin_dsr | input | 1 | External DSR |
| pin_ri | input | 1 | External RI |
| pin_cd | input | 1 | External CD |
| pin_rx | input | 1 | External serial input |
| pin_tx | output | 1 | External serial output |
| pin_dtr | output | 1 | External DTR |
| pin_rts | output | 1 | External RTS |
| core_tx | input | 1 | Serial stream from the transmitter |
| core_rx | output | 1 | Serial stream to the receiver |

## Verification
The bench walks through all 32 control settings. For each one it steps the four external modem pins through all 16 patterns, masked so that consecutive steps move different subsets of lines. In loopback this shows whether each status line takes the right control bit and whether the pins leak through. Out of loopback it tells a missed change or a wrong flag position apart from a wrong RI edge sense. The interrupt is checked with the enable both on and off. The serial routing is checked with the transmit stream and the RX pin held at opposite values. Directed steps pin down the synchronizer latency, how long a flag holds, and a read that lands in the same cycle as a change.

// File: rtl/mdmlb_pkg.sv
package mdmlb_pkg;

  // control register bit positions (behavioural: loopback maps bits 3..0 onto status lines)
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_AUX  = 2;
  localparam int CB_IEN  = 3;
  localparam int CB_LOOP = 4;
  localparam int CTL_W   = 5;

  // status line order inside a 4-bit level vector: {cd, ri, dsr, cts}
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_CD  = 3;
  localparam int LINES  = 4;

  typedef logic [LINES-1:0] mdm_lines_t;

  // loopback source for each status line, indexed by line
  function automatic mdm_lines_t f_loop_src(input logic [CTL_W-1:0] ctl);
    mdm_lines_t r;
    r[LN_CTS] = ctl[CB_DTR];
    r[LN_DSR] = ctl[CB_RTS];
    r[LN_RI]  = ctl[CB_AUX];
    r[LN_CD]  = ctl[CB_IEN];
    return r;
  endfunction

  // change events: any edge on CTS/DSR/CD, trailing edge only on RI
  function automatic mdm_lines_t f_events(input mdm_lines_t prev, input mdm_lines_t cur);
    mdm_lines_t e;
    e         = prev ^ cur;
    e[LN_RI]  = prev[LN_RI] & ~cur[LN_RI];
    return e;
  endfunction

endpackage

// File: rtl/mdmlb_sync.sv
module mdmlb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[LAST];

endmodule

// File: rtl/mdmlb_ctl.sv
module mdmlb_ctl
  import mdmlb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [DATA_W-1:0] rdata
);
  logic unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:CTL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= wdata[CTL_W-1:0];
  end

  assign rdata = DATA_W'(ctl_q);

  p_hold_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl_q));

endmodule

// File: rtl/mdmlb_route.sv
module mdmlb_route
  import mdmlb_pkg::*;
(
  input  logic             loop_en,
  input  logic [CTL_W-1:0] ctl_q,
  input  mdm_lines_t       pin_lines,
  input  logic             core_tx,
  input  logic             pin_rx,
  output mdm_lines_t       lines,
  output logic             core_rx,
  output logic             pin_tx,
  output logic             pin_dtr,
  output logic             pin_rts
);
  mdm_lines_t loop_src;

  assign loop_src = f_loop_src(ctl_q);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = loop_en ? loop_src[i] : pin_lines[i];
  end

  assign core_rx = loop_en ? core_tx : pin_rx;
  assign pin_tx  = loop_en ? 1'b1    : core_tx;
  assign pin_dtr = ~loop_en & ctl_q[CB_DTR];
  assign pin_rts = ~loop_en & ctl_q[CB_RTS];

endmodule

// File: rtl/mdmlb_status.sv
module mdmlb_status
  import mdmlb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mdm_lines_t lines,
  input  logic       rd,
  input  logic       msi_en,
  output mdm_lines_t events,
  output mdm_lines_t flags_q,
  output logic [7:0] sts,
  output logic       irq
);
  mdm_lines_t prev_q;
  mdm_lines_t flags_d;

  assign events  = f_events(prev_q, lines);
  assign flags_d = (rd ? '0 : flags_q) | events;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= lines;
      flags_q <= flags_d;
    end
  end

  assign sts = {lines, flags_q};
  assign irq = msi_en & (|flags_q);

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) |=> ((flags_q & $past(events)) == $past(events)));

  p_ri_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_q[LN_RI] && lines[LN_RI] && !flags_q[LN_RI]) |=> !flags_q[LN_RI]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && events == '0) |=> (flags_q == '0));

endmodule

// File: rtl/uart_modem_loopback.sv
module uart_modem_loopback
  import mdmlb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              sts_rd,
  output logic [7:0]        sts_rdata,
  input  logic              msi_en,
  output logic              irq_modem,
  input  logic              pin_cts,
  input  logic              pin_dsr,
  input  logic              pin_ri,
  input  logic              pin_cd,
  input  logic              pin_rx,
  output logic              pin_tx,
  output logic              pin_dtr,
  output logic              pin_rts,
  input  logic              core_tx,
  output logic              core_rx
);
  logic [CTL_W-1:0] ctl_q;
  mdm_lines_t       pin_raw;
  mdm_lines_t       pin_sync;
  mdm_lines_t       lines;
  mdm_lines_t       events;
  mdm_lines_t       flags_q;
  logic             loop_en;

  assign pin_raw[LN_CTS] = pin_cts;
  assign pin_raw[LN_DSR] = pin_dsr;
  assign pin_raw[LN_RI]  = pin_ri;
  assign pin_raw[LN_CD]  = pin_cd;

  mdmlb_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl_q (ctl_q),
    .rdata (ctl_rdata)
  );

  assign loop_en = ctl_q[CB_LOOP];

  mdmlb_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_sync)
  );

  mdmlb_route u_route (
    .loop_en   (loop_en),
    .ctl_q     (ctl_q),
    .pin_lines (pin_sync),
    .core_tx   (core_tx),
    .pin_rx    (pin_rx),
    .lines     (lines),
    .core_rx   (core_rx),
    .pin_tx    (pin_tx),
    .pin_dtr   (pin_dtr),
    .pin_rts   (pin_rts)
  );

  mdmlb_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (lines),
    .rd      (sts_rd),
    .msi_en  (msi_en),
    .events  (events),
    .flags_q (flags_q),
    .sts     (sts_rdata),
    .irq     (irq_modem)
  );

  p_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CB_LOOP] |-> (core_rx == core_tx));

  p_quiet_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CB_LOOP] |-> (pin_tx && !pin_dtr && !pin_rts));

  p_loop_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CB_LOOP] |-> (sts_rdata[7:4] == ctl_rdata[3:0]));

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_modem |-> (msi_en && (sts_rdata[3:0] != 4'h0)));

  p_irq_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && (flags_q != '0)) |-> irq_modem);

endmodule

// File: tb/uart_modem_loopback_bench.sv
module uart_modem_loopback_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       sts_rd = 1'b0;
  logic [7:0] sts_rdata;
  logic       msi_en = 1'b0;
  logic       irq_modem;
  logic       pin_cts = 1'b0, pin_dsr = 1'b0, pin_ri = 1'b0, pin_cd = 1'b0;
  logic       pin_rx = 1'b0;
  logic       pin_tx, pin_dtr, pin_rts;
  logic       core_tx = 1'b0;
  logic       core_rx;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_modem_loopback u_uart_modem_loopback (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .msi_en(msi_en), .irq_modem(irq_modem), .pin_cts(pin_cts),
    .pin_dsr(pin_dsr), .pin_ri(pin_ri), .pin_cd(pin_cd), .pin_rx(pin_rx),
    .pin_tx(pin_tx), .pin_dtr(pin_dtr), .pin_rts(pin_rts),
    .core_tx(core_tx), .core_rx(core_rx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic read_sts();
    sts_rd = 1'b1;
    tick();
    sts_rd = 1'b0;
  endtask

  // pins given as {cd, ri, dsr, cts}
  task automatic set_pins(input logic [3:0] p);
    pin_cts = p[0]; pin_dsr = p[1]; pin_ri = p[2]; pin_cd = p[3];
  endtask

  // status line levels seen by software, {cd, ri, dsr, cts}
  function automatic logic [3:0] want_lvl(input logic [3:0] p, input logic [4:0] c);
    logic [3:0] r;
    if (c[4] == 1'b1) begin
      r[0] = c[0]; r[1] = c[1]; r[2] = c[2]; r[3] = c[3];
    end else begin
      r = p;
    end
    return r;
  endfunction

  function automatic logic [3:0] want_flags(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r;
    r[0] = (a[0] != b[0]);
    r[1] = (a[1] != b[1]);
    r[2] = (a[2] == 1'b1) && (b[2] == 1'b0);
    r[3] = (a[3] != b[3]);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #800000;
    misses++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0] old_lvl;
    logic [3:0] new_lvl;
    logic [3:0] cur_pins;
    logic [4:0] cur_ctl;
    logic [3:0] fl;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10 reset state
    chk("R10 ctl", 32'(ctl_rdata), 32'h00);
    chk("R10 sts", 32'(sts_rdata), 32'h00);
    chk("R10 irq", 32'(irq_modem), 32'h0);
    core_tx = 1'b1; #0.1;
    chk("R1 tx follow", 32'(pin_tx), 32'h1);
    core_tx = 1'b0;

    // R9 upper control bits ignored
    write_ctl(8'hE3);
    chk("R9 readback", 32'(ctl_rdata), 32'h03);
    chk("R2 dtr", 32'(pin_dtr), 32'h1);
    chk("R2 rts", 32'(pin_rts), 32'h1);
    write_ctl(8'h00);

    // R4 synchronizer latency on CTS
    pin_cts = 1'b1;
    tick();
    chk("R4 lvl after 1 edge", 32'(sts_rdata[4]), 32'h0);
    tick();
    chk("R4 lvl after 2 edges", 32'(sts_rdata[4]), 32'h1);
    chk("R4 flag not yet", 32'(sts_rdata[0]), 32'h0);
    tick();
    chk("R4 flag after 3 edges", 32'(sts_rdata[0]), 32'h1);
    // R6 sticky
    repeat (10) tick();
    chk("R6 flag held", 32'(sts_rdata[0]), 32'h1);
    msi_en = 1'b1; #0.1;
    chk("R8 irq", 32'(irq_modem), 32'h1);
    read_sts();
    chk("R7 cleared", 32'(sts_rdata[3:0]), 32'h0);
    chk("R8 irq low", 32'(irq_modem), 32'h0);
    pin_cts = 1'b0;
    repeat (4) tick();
    read_sts();

    // R7 read in the same cycle as a change
    write_ctl(8'h10);
    read_sts();
    ctl_wr = 1'b1; ctl_wdata = 8'h11;
    tick();
    ctl_wr = 1'b0; sts_rd = 1'b1;
    tick();
    sts_rd = 1'b0;
    chk("R7 event wins over read", 32'(sts_rdata[3:0]), 32'h1);
    read_sts();
    chk("R7 later read clears", 32'(sts_rdata[3:0]), 32'h0);

    // R5 RI edge sense in loopback
    write_ctl(8'h14);
    tick();
    chk("R5 RI rise lvl", 32'(sts_rdata[6]), 32'h1);
    chk("R5 RI rise no flag", 32'(sts_rdata[2]), 32'h0);
    write_ctl(8'h10);
    tick();
    chk("R5 RI fall flag", 32'(sts_rdata[2]), 32'h1);
    read_sts();
    write_ctl(8'h00);
    repeat (4) tick();
    read_sts();

    // exhaustive sweep: all control settings x all pin patterns
    cur_pins = 4'h0;
    cur_ctl  = 5'h00;
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] np;
        logic [4:0] nc;
        np = 4'(p) ^ 4'(c);
        nc = 5'(c);
        old_lvl = want_lvl(cur_pins, cur_ctl);
        new_lvl = want_lvl(np, nc);
        fl = want_flags(old_lvl, new_lvl);
        msi_en = 1'((c + p) & 1);
        set_pins(np);
        write_ctl({3'b101, nc});
        repeat (3) tick();
        cur_pins = np;
        cur_ctl = nc;
        if (nc[4]) chk("R3 loop levels", 32'(sts_rdata[7:4]), 32'(new_lvl));
        else       chk("R4 pin levels", 32'(sts_rdata[7:4]), 32'(new_lvl));
        chk("R4 R5 flags", 32'(sts_rdata[3:0]), 32'(fl));
        chk("R8 irq", 32'(irq_modem), 32'(msi_en && (fl != 4'h0)));
        chk("R9 readback", 32'(ctl_rdata), 32'(nc));
        core_tx = np[0] ^ np[3];
        pin_rx  = ~core_tx;
        #0.1;
        chk("R1 core_rx", 32'(core_rx), nc[4] ? 32'(core_tx) : 32'(pin_rx));
        chk("R2 pin_tx", 32'(pin_tx), nc[4] ? 32'h1 : 32'(core_tx));
        chk("R2 dtr/rts", 32'({pin_rts, pin_dtr}), nc[4] ? 32'h0 : 32'(nc[1:0]));
        read_sts();
        chk("R7 read clears", 32'(sts_rdata[3:0]), 32'h0);
      end
    end

    finish_run();
  end

endmodule